// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual byte address into a physical byte address by walking a two-level table held in memory. The top ten address bits select an entry in a root table, whose physical page number is supplied with each request. That entry names the page of a leaf table. The next ten bits select an entry in the leaf table, and the low twelve bits pass through untouched as the byte offset within a 4096-byte page. Every table holds 1024 one-word entries and fills exactly one page.

Table entries are read one at a time through a single-outstanding memory port. The walker holds a request until the memory acknowledges it. At the leaf, the walker maintains usage bits. A translation that finds the accessed bit clear, or that writes a page whose modified bit is clear, stores the entry back with those bits set before it reports completion. Missing tables or pages end the walk with a not-present fault. A write to a page that does not permit writing ends with a protection fault.

A request is accepted only while the walker is idle. The result is reported with a one-cycle completion strobe, and the result outputs hold their values until the next completion.

Top module: `pw_walker`

## Requirements
- R1: After reset, `done`, `mem_req`, `mem_we`, `fault_np` and `fault_prot` are 0, and `pa` and `rights` are 0.
- R2: The first memory access of a walk is a read (`mem_we`=0) at address `{root_ppn, vaddr[31:22], 2'b00}`.
- R3: If bit 0 (present) of the root entry is 0, the walk ends with `fault_np`=1 and `fault_prot`=0, and no further memory access is made.
- R4: Otherwise the second access is a read at `{root_entry[31:12], vaddr[21:12], 2'b00}`.
- R5: If bit 0 (present) of the leaf entry is 0, the walk ends with `fault_np`=1 and no write-back.
- R6: A write request whose present leaf entry has bit 1 (write permitted) at 0 ends with `fault_prot`=1 and `fault_np`=0, and no write-back.
- R7: A walk that succeeds reports `pa` = `{leaf[31:12], vaddr[11:0]}` and `rights` = the low 12 bits of the leaf as updated by R8, with both fault flags at 0. A faulting walk reports `pa`=0 and `rights`=0.
- R8: A write-back (`mem_we`=1) to the leaf address happens exactly when bit 2 (accessed) is 0, or when the request is a write and bit 3 (modified) is 0. The data written is the leaf with bit 2 set, and also bit 3 set for a write. No other bit changes.
- R9: While `mem_req` is 1 and `mem_ack` is 0, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged in the next cycle.
- R10: `req_valid` is ignored unless the walker is idle. This includes the cycle in which `done` is 1.
- R11: Every accepted request produces exactly one `done` pulse, one cycle wide. `mem_req` is 0 while `done` is 1, and the two fault flags are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start a walk (sampled only while idle) |
| req_vaddr | input | 32 | Virtual byte address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| root_ppn | input | 20 | Physical page number of the root table |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Pending access is a write-back |
| mem_addr | output | 32 | Byte address of the table entry |
| mem_wdata | output | 32 | Entry data for a write-back |
| mem_ack | input | 1 | Memory completes the pending access this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| done | output | 1 | One-cycle completion strobe |
| pa | output | 32 | Translated physical address |
| rights | output | 12 | Low 12 bits of the leaf entry |
| fault_np | output | 1 | Root or leaf entry not present |
| fault_prot | output | 1 | Write to a page that is not writable |

## Verification
A new request can arrive in the same cycle as the completion strobe of the previous walk. It can also arrive while a table read is still waiting for its acknowledge. The bench raises `req_valid` with a different address in both of these windows. It then judges that the running walk reports the result of its original address, and that no memory request follows the completion. Random acknowledge latency makes the completion of a memory access land against both of these events.

// File: rtl/pw_pkg.sv
package pw_pkg;

    // leaf / root entry bit positions
    localparam int PTE_PRESENT = 0;
    localparam int PTE_WR_OK   = 1;
    localparam int PTE_ACCESS  = 2;
    localparam int PTE_DIRTY   = 3;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD_L1  = 3'd1,
        ST_RD_L2  = 3'd2,
        ST_UPDATE = 3'd3,
        ST_DONE   = 3'd4
    } walk_st_e;

endpackage

// File: rtl/pw_entry_addr.sv
module pw_entry_addr #(
    parameter int PPN_W = 20,
    parameter int IDX_W = 10,
    parameter int OFF_W = 12
) (
    input  logic [PPN_W-1:0]       table_ppn,
    input  logic [IDX_W-1:0]       index,
    output logic [PPN_W+OFF_W-1:0] entry_addr
);
    localparam int PAD_W = OFF_W - IDX_W;

    assign entry_addr = {table_ppn, index, {PAD_W{1'b0}}};

endmodule

// File: rtl/pw_leaf_eval.sv
module pw_leaf_eval
    import pw_pkg::*;
#(
    parameter int PTE_W = 32
) (
    input  logic [PTE_W-1:0] pte,
    input  logic             is_write,
    output logic             present,
    output logic             perm_ok,
    output logic             need_update,
    output logic [PTE_W-1:0] pte_upd
);
    always_comb begin
        present     = pte[PTE_PRESENT];
        perm_ok     = !is_write || pte[PTE_WR_OK];
        need_update = !pte[PTE_ACCESS] || (is_write && !pte[PTE_DIRTY]);
        pte_upd     = pte;
        pte_upd[PTE_ACCESS] = 1'b1;
        if (is_write) begin
            pte_upd[PTE_DIRTY] = 1'b1;
        end
    end

endmodule

// File: rtl/pw_walker.sv
module pw_walker
    import pw_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int PPN_W = 20,
    parameter int IDX_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic [PPN_W-1:0]  root_ppn,
    output logic              mem_req,
    output logic              mem_we,
    output logic [VA_W-1:0]   mem_addr,
    output logic [VA_W-1:0]   mem_wdata,
    input  logic              mem_ack,
    input  logic [VA_W-1:0]   mem_rdata,
    output logic              done,
    output logic [VA_W-1:0]   pa,
    output logic [VA_W-PPN_W-1:0] rights,
    output logic              fault_np,
    output logic              fault_prot
);
    localparam int OFF_W  = VA_W - PPN_W;
    localparam int L1_LSB = OFF_W + IDX_W;
    localparam int L2_LSB = OFF_W;

    typedef struct packed {
        walk_st_e          st;
        logic [VA_W-1:0]   va;
        logic              wr;
        logic [PPN_W-1:0]  root;
        logic [PPN_W-1:0]  l2_ppn;
        logic [VA_W-1:0]   leaf;
        logic [VA_W-1:0]   pa;
        logic [OFF_W-1:0]  rights;
        logic              f_np;
        logic              f_prot;
    } walk_regs_t;

    walk_regs_t q, d;

    logic [VA_W-1:0] l1_addr;
    logic [VA_W-1:0] l2_addr;
    logic            leaf_present;
    logic            leaf_perm_ok;
    logic            leaf_need_upd;
    logic [VA_W-1:0] leaf_upd;

    pw_entry_addr #(.PPN_W(PPN_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) i_l1_addr (
        .table_ppn (q.root),
        .index     (q.va[L1_LSB +: IDX_W]),
        .entry_addr(l1_addr)
    );

    pw_entry_addr #(.PPN_W(PPN_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) i_l2_addr (
        .table_ppn (q.l2_ppn),
        .index     (q.va[L2_LSB +: IDX_W]),
        .entry_addr(l2_addr)
    );

    pw_leaf_eval #(.PTE_W(VA_W)) i_leaf_eval (
        .pte        (mem_rdata),
        .is_write   (q.wr),
        .present    (leaf_present),
        .perm_ok    (leaf_perm_ok),
        .need_update(leaf_need_upd),
        .pte_upd    (leaf_upd)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.va   = req_vaddr;
                    d.wr   = req_write;
                    d.root = root_ppn;
                    d.st   = ST_RD_L1;
                end
            end
            ST_RD_L1: begin
                if (mem_ack) begin
                    if (!mem_rdata[PTE_PRESENT]) begin
                        d.f_np   = 1'b1;
                        d.f_prot = 1'b0;
                        d.pa     = '0;
                        d.rights = '0;
                        d.st     = ST_DONE;
                    end else begin
                        d.l2_ppn = mem_rdata[VA_W-1:OFF_W];
                        d.st     = ST_RD_L2;
                    end
                end
            end
            ST_RD_L2: begin
                if (mem_ack) begin
                    d.leaf = leaf_upd;
                    if (!leaf_present || !leaf_perm_ok) begin
                        d.f_np   = !leaf_present;
                        d.f_prot = leaf_present;
                        d.pa     = '0;
                        d.rights = '0;
                        d.st     = ST_DONE;
                    end else if (leaf_need_upd) begin
                        d.st     = ST_UPDATE;
                    end else begin
                        d.f_np   = 1'b0;
                        d.f_prot = 1'b0;
                        d.pa     = {leaf_upd[VA_W-1:OFF_W], q.va[OFF_W-1:0]};
                        d.rights = leaf_upd[OFF_W-1:0];
                        d.st     = ST_DONE;
                    end
                end
            end
            ST_UPDATE: begin
                if (mem_ack) begin
                    d.f_np   = 1'b0;
                    d.f_prot = 1'b0;
                    d.pa     = {q.leaf[VA_W-1:OFF_W], q.va[OFF_W-1:0]};
                    d.rights = q.leaf[OFF_W-1:0];
                    d.st     = ST_DONE;
                end
            end
            ST_DONE: begin
                d.st = ST_IDLE;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        mem_req   = (q.st == ST_RD_L1) || (q.st == ST_RD_L2) || (q.st == ST_UPDATE);
        mem_we    = (q.st == ST_UPDATE);
        mem_addr  = (q.st == ST_RD_L1) ? l1_addr : l2_addr;
        mem_wdata = (q.st == ST_UPDATE) ? q.leaf : '0;
    end

    assign done       = (q.st == ST_DONE);
    assign pa         = q.pa;
    assign rights     = q.rights;
    assign fault_np   = q.f_np;
    assign fault_prot = q.f_prot;

endmodule

// File: rtl/pw_walker_chk.sv
module pw_walker_chk
    import pw_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        done,
    input logic [31:0] pa,
    input logic [11:0] rights,
    input logic        fault_np,
    input logic        fault_prot
);
    // R9: a pending access is held unchanged until acknowledged
    a_r9_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

    // R11: completion strobe is one cycle wide
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: fault flags exclusive when reported
    a_r11_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(fault_np && fault_prot));

    // R11: no memory access during completion
    a_r11_no_req_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    // R8: every write-back carries the accessed bit
    a_r8_wb_access: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[PTE_ACCESS]);

    // R7: a faulting walk reports zero address and rights
    a_r7_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done && (fault_np || fault_prot) |-> (pa == 32'd0) && (rights == 12'd0));

endmodule

bind pw_walker pw_walker_chk i_pw_walker_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .done      (done),
    .pa        (pa),
    .rights    (rights),
    .fault_np  (fault_np),
    .fault_prot(fault_prot)
);

// File: tb/test_pw_walker.sv
`timescale 1ns/1ps
module test_pw_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [19:0] root_ppn = '0;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic [31:0] pa;
    logic [11:0] rights;
    logic        fault_np;
    logic        fault_prot;

    always #2.5 clk = ~clk;

    pw_walker i_pw_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .root_ppn(root_ppn), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .pa(pa), .rights(rights), .fault_np(fault_np), .fault_prot(fault_prot)
    );

    logic [31:0] mem [0:4095];
    int          n_rd, n_wr;
    logic [31:0] rd_addr0, rd_addr1, wr_addr, wr_data;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory responder, random latency 0..2 cycles
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req) begin
                int lat;
                lat = $urandom_range(0, 2);
                repeat (lat) @(negedge clk);
                if (mem_we) begin
                    mem[mem_addr[13:2]] = mem_wdata;
                    wr_addr = mem_addr;
                    wr_data = mem_wdata;
                    n_wr++;
                end else begin
                    mem_rdata = mem[mem_addr[13:2]];
                    if (n_rd == 0) rd_addr0 = mem_addr;
                    if (n_rd == 1) rd_addr1 = mem_addr;
                    n_rd++;
                end
                mem_ack = 1'b1;
            end
        end
    end

    // mode: 0 plain, 1 extra request mid-walk, 2 extra request in completion cycle
    task automatic run(input logic [31:0] va, input logic wr, input logic [1:0] root,
                       input logic [31:0] l1e, input logic [31:0] l2e, input int mode);
        logic [31:0] l1a, l2a, exp_pa, exp_wb;
        logic [11:0] exp_rights;
        logic        exp_np, exp_prot, exp_wbv;
        int          waited;
        l1a = {10'd0, root, va[31:22], 2'b00};
        l2a = {l1e[31:12], va[21:12], 2'b00};
        mem[l1a[13:2]] = l1e;
        if (l1e[0]) mem[l2a[13:2]] = l2e;
        // expected result from the requirements
        exp_np = 1'b0; exp_prot = 1'b0; exp_wbv = 1'b0;
        exp_pa = '0; exp_rights = '0; exp_wb = l2e | 32'h4 | (wr ? 32'h8 : 32'h0);
        if (!l1e[0] || !l2e[0]) exp_np = 1'b1;
        else if (wr && !l2e[1]) exp_prot = 1'b1;
        else begin
            exp_wbv    = !l2e[2] || (wr && !l2e[3]);
            exp_pa     = {l2e[31:12], va[11:0]};
            exp_rights = exp_wb[11:0];
        end
        n_rd = 0; n_wr = 0;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr; root_ppn = {18'd0, root};
        @(negedge clk);
        req_valid = 1'b0;
        if (mode == 1) begin
            req_valid = 1'b1; req_vaddr = va ^ 32'hFFC0_0000; req_write = ~wr; root_ppn = 20'd3;
            @(negedge clk);
            req_valid = 1'b0;
        end
        waited = 0;
        while (!done && waited < 100) begin
            @(negedge clk);
            waited++;
        end
        check("R11 done seen", {31'd0, done}, 32'd1);
        check("R2 root entry address", rd_addr0, l1a);
        check("R3 R5 fault_np", {31'd0, fault_np}, {31'd0, exp_np});
        check("R6 fault_prot", {31'd0, fault_prot}, {31'd0, exp_prot});
        check("R7 pa", pa, exp_pa);
        check("R7 rights", {20'd0, rights}, {20'd0, exp_rights});
        if (!l1e[0]) check("R3 single read", n_rd, 1);
        else begin
            check("R4 leaf entry address", rd_addr1, l2a);
            check("R4 two reads", n_rd, 2);
        end
        check("R8 write-back count", n_wr, exp_wbv ? 1 : 0);
        if (exp_wbv) begin
            check("R8 write-back address", wr_addr, l2a);
            check("R8 write-back data", wr_data, exp_wb);
        end
        if (mode == 2) begin
            req_valid = 1'b1; req_vaddr = va ^ 32'h0040_0000; req_write = wr; root_ppn = {18'd0, root};
        end
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 done one cycle", {31'd0, done}, 32'd0);
        if (mode == 2) begin
            for (int i = 0; i < 4; i++) begin
                check("R10 no access after done-cycle request", {31'd0, mem_req}, 32'd0);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 done", {31'd0, done}, 32'd0);
        check("R1 mem_req", {31'd0, mem_req}, 32'd0);
        check("R1 mem_we", {31'd0, mem_we}, 32'd0);
        check("R1 pa", pa, 32'd0);
        check("R1 rights", {20'd0, rights}, 32'd0);
        check("R1 faults", {30'd0, fault_np, fault_prot}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // directed corners
        run(32'h1234_5678, 1'b0, 2'd0, 32'h0000_1000, 32'hABCD_E001, 0); // R3: root entry absent
        run(32'h1234_5678, 1'b0, 2'd0, 32'h0000_1001, 32'hABCD_E000, 0); // R5: leaf absent
        run(32'h8765_4321, 1'b1, 2'd1, 32'h0000_2001, 32'h5555_50F5, 0); // R6: read-only write
        run(32'h8765_4321, 1'b0, 2'd1, 32'h0000_2001, 32'h5555_5005, 0); // R8: accessed set, no wb
        run(32'hCAFE_0ABC, 1'b1, 2'd2, 32'h0000_3001, 32'h7777_700F, 0); // R8: both set, no wb
        run(32'hCAFE_0ABC, 1'b1, 2'd2, 32'h0000_3001, 32'h7777_7007, 0); // R8: wb sets modified
        run(32'hCAFE_0ABC, 1'b0, 2'd2, 32'h0000_3001, 32'h7777_7A01, 0); // R8: read wb sets accessed
        run(32'h0040_1FFF, 1'b0, 2'd3, 32'h0000_0001, 32'h1111_1003, 1); // R10: mid-walk request
        run(32'hFFFF_F000, 1'b1, 2'd0, 32'h0000_2001, 32'h2222_2003, 2); // R10: request in done cycle

        // random traffic
        for (int n = 0; n < 300; n++) begin
            logic [1:0]  rt, lp;
            logic [31:0] va, l1e, l2e;
            rt  = 2'($urandom_range(0, 3));
            lp  = 2'((rt + 2'($urandom_range(1, 3))) % 4);
            va  = $urandom;
            l1e = {18'd0, lp, 11'($urandom), ($urandom_range(0, 9) != 0)};
            l2e = $urandom;
            l2e[0] = ($urandom_range(0, 9) != 0);
            run(va, 1'($urandom), rt, l1e, l2e, int'($urandom_range(0, 2)));
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule